// File: doc/BRIEF.md
# DMA Channel Interrupt Merger

This block gathers completion events from a set of DMA channel engines and folds them into a single level-sensitive interrupt line. Each channel keeps a sticky word of event flags. A per-channel control mask selects which of these flags may raise the channel. A channel whose selected flags are nonzero latches a bit in a global pending word. A global enable word then decides which pending channels drive the interrupt output. Software reaches all of this over a simple register bus with same-cycle read data. The bus can also read a word that reports which channels are idle.

Pending is tracked at two levels, and each level is cleared on its own. Clearing a channel's event flags does not clear its global pending bit. Clearing the global pending bit while the channel's selected flags are still set makes the bit return.

Each channel's global pending bit is produced by a small state machine with three states:
- **CH_QUIET**: the bit is clear and the channel's masked event level is low.
- **CH_PEND**: the bit is set.
- **CH_RECHK**: the bit has just been cleared and the level is checked again.

The transitions are:
- **QUIET→PEND** on a high masked level.
- **PEND→RECHK** on a one-written clear, unless a fresh rising edge of the level arrives in the same cycle (then the state stays in PEND).
- **RECHK→PEND** if the level is still high.
- **RECHK→QUIET** otherwise.

Top module: `dma_irq_merge`

## Requirements
- R1: After reset, every register reads zero: pending, enable, and each channel's control and status. The interrupt output is low.
- R2: A one-cycle event pulse on bit k of a channel sets status bit k of that channel, and the bit stays set. The bits are: 0 block done, 1 list done, 2 frame done, 3 half frame, 4 last frame. Status is read at channel offset 0x44, in bits [4:0]. Bits above 4 read zero.
- R3: A write to a channel's status register clears each status bit written as 0 and keeps each bit written as 1. An event pulse arriving in the same cycle as the write still sets its bit.
- R4: The channel control register at channel offset 0x44-4 (0x40) is read/write in bits [4:0]. A channel raises its pending source only when control AND status is nonzero, so events whose control bit is zero never set pending.
- R5: Global pending bit i (address 0x00) reads 1 from the second clock edge after the event pulse that makes channel i's masked level nonzero. It stays set after the channel's status is cleared.
- R6: Writing ones to 0x00 clears those pending bits; written zeros do nothing. If channel i's masked level is still high, bit i reads 0 for one cycle and then sets again. If the level rises in the same cycle as the clear, the bit stays set.
- R7: The global enable register at 0x10 is read/write, with one bit per channel in bits [NUM_CH-1:0].
- R8: The interrupt output is high exactly when some channel has both its pending bit and its enable bit set. It follows register changes with no extra delay.
- R9: The word at 0x2C reflects the idle inputs directly, with bit i high when channel i is inactive. Writes to 0x2C are ignored.
- R10: Channel i's window starts at 0x100 + i*0x100. Addresses outside the defined registers read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pulse | input | NUM_CH*EV_W | Event pulses; channel i occupies bits [i*EV_W +: EV_W] |
| ch_idle | input | NUM_CH | Per-channel idle flags from the engines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address (same cycle) |
| irq | output | 1 | Merged level-sensitive interrupt |

## Verification
There are two same-cycle collisions that the design must resolve.

The first is a global pending clear landing on the same edge as a new rising edge of the channel's masked level. The bench provokes it by clearing a channel's status so its level drops, while its pending bit stays set. It then pulses an event on one edge and writes the clear on the next edge. The pending bit is read right after that edge and must still be 1.

The second is an event pulse arriving together with a status write that zeroes that channel's status. The status read-back must show the pulsed bit set and the other bits cleared.

// File: rtl/dirq_pkg.sv
package dirq_pkg;

    // Register offsets inside the global page and inside a channel window
    localparam logic [7:0] OFF_PEND = 8'h00;
    localparam logic [7:0] OFF_EN   = 8'h10;
    localparam logic [7:0] OFF_IDLE = 8'h2C;
    localparam logic [7:0] OFF_CTL  = 8'h40;
    localparam logic [7:0] OFF_STAT = 8'h44;

    typedef enum logic [1:0] {
        CH_QUIET = 2'd0,
        CH_PEND  = 2'd1,
        CH_RECHK = 2'd2
    } pend_state_e;

endpackage

// File: rtl/dirq_chan_regs.sv
module dirq_chan_regs #(
    parameter int EV_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [EV_W-1:0] ev_i,
    input  logic            ctl_we_i,
    input  logic            stat_we_i,
    input  logic [EV_W-1:0] wdata_i,
    output logic [EV_W-1:0] ctl_o,
    output logic [EV_W-1:0] stat_o,
    output logic            level_o
);

    logic [EV_W-1:0] ctl_q;
    logic [EV_W-1:0] stat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q  <= '0;
            stat_q <= '0;
        end else begin
            if (ctl_we_i) begin
                ctl_q <= wdata_i;
            end
            // zero-written bits clear, an incoming event always wins
            stat_q <= (stat_we_i ? (stat_q & wdata_i) : stat_q) | ev_i;
        end
    end

    assign ctl_o   = ctl_q;
    assign stat_o  = stat_q;
    assign level_o = |(ctl_q & stat_q);

    AST_EV_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_i) |=> ((stat_q & $past(ev_i)) == $past(ev_i))); // R2

    AST_STAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_we_i |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R3

endmodule

// File: rtl/dirq_pend_fsm.sv
module dirq_pend_fsm
    import dirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    input  logic clr_i,
    output logic pend_o
);

    pend_state_e state_q, state_d;
    logic        level_q;
    logic        rise;

    assign rise = level_i & ~level_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_QUIET;
            level_q <= 1'b0;
        end else begin
            state_q <= state_d;
            level_q <= level_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_QUIET: if (level_i) state_d = CH_PEND;
            CH_PEND:  if (clr_i && !rise) state_d = CH_RECHK;
            CH_RECHK: state_d = level_i ? CH_PEND : CH_QUIET;
            default:  state_d = CH_QUIET;
        endcase
    end

    always_comb begin
        pend_o = (state_q == CH_PEND);
    end

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_PEND && !clr_i) |=> (state_q == CH_PEND)); // R5

    AST_CLR_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_PEND && clr_i && level_i && !level_q) |=> pend_o); // R6

    AST_RECHK_BRIEF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RECHK) |=> (state_q != CH_RECHK)); // R6

endmodule

// File: rtl/dirq_regbus.sv
module dirq_regbus
    import dirq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int EV_W   = 5,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                       sel_i,
    input  logic                       wr_i,
    input  logic [ADDR_W-1:0]          addr_i,
    input  logic [DATA_W-1:0]          wdata_i,
    input  logic [NUM_CH-1:0]          pend_i,
    input  logic [NUM_CH-1:0]          en_i,
    input  logic [NUM_CH-1:0]          idle_i,
    input  logic [NUM_CH-1:0][EV_W-1:0] ctl_i,
    input  logic [NUM_CH-1:0][EV_W-1:0] stat_i,
    output logic [DATA_W-1:0]          rdata_o,
    output logic [NUM_CH-1:0]          pend_clr_o,
    output logic                       en_we_o,
    output logic [NUM_CH-1:0]          ctl_we_o,
    output logic [NUM_CH-1:0]          stat_we_o
);

    localparam int SEL_W = ADDR_W - 8;

    logic [SEL_W-1:0] page;
    logic [7:0]       off;
    logic             wr_hit;

    assign page   = addr_i[ADDR_W-1:8];
    assign off    = addr_i[7:0];
    assign wr_hit = sel_i & wr_i;

    always_comb begin
        rdata_o    = '0;
        pend_clr_o = '0;
        en_we_o    = 1'b0;
        ctl_we_o   = '0;
        stat_we_o  = '0;
        if (page == '0) begin
            case (off)
                OFF_PEND: begin
                    rdata_o = DATA_W'(pend_i);
                    if (wr_hit) pend_clr_o = wdata_i[NUM_CH-1:0];
                end
                OFF_EN: begin
                    rdata_o = DATA_W'(en_i);
                    en_we_o = wr_hit;
                end
                OFF_IDLE: rdata_o = DATA_W'(idle_i);
                default: ;
            endcase
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (page == SEL_W'(i + 1)) begin
                if (off == OFF_CTL) begin
                    rdata_o     = DATA_W'(ctl_i[i]);
                    ctl_we_o[i] = wr_hit;
                end else if (off == OFF_STAT) begin
                    rdata_o      = DATA_W'(stat_i[i]);
                    stat_we_o[i] = wr_hit;
                end
            end
        end
    end

endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge
    import dirq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int EV_W   = 5,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_CH*EV_W-1:0] ev_pulse,
    input  logic [NUM_CH-1:0]      ch_idle,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   irq
);

    logic [NUM_CH-1:0][EV_W-1:0] ctl_w;
    logic [NUM_CH-1:0][EV_W-1:0] stat_w;
    logic [NUM_CH-1:0]           level_w;
    logic [NUM_CH-1:0]           pend_w;
    logic [NUM_CH-1:0]           pend_clr_w;
    logic [NUM_CH-1:0]           ctl_we_w;
    logic [NUM_CH-1:0]           stat_we_w;
    logic                        en_we_w;
    logic [NUM_CH-1:0]           en_q;

    dirq_regbus #(
        .NUM_CH (NUM_CH),
        .EV_W   (EV_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_bus (
        .sel_i      (bus_sel),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .pend_i     (pend_w),
        .en_i       (en_q),
        .idle_i     (ch_idle),
        .ctl_i      (ctl_w),
        .stat_i     (stat_w),
        .rdata_o    (bus_rdata),
        .pend_clr_o (pend_clr_w),
        .en_we_o    (en_we_w),
        .ctl_we_o   (ctl_we_w),
        .stat_we_o  (stat_we_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dirq_chan_regs #(.EV_W(EV_W)) u_regs (
            .clk       (clk),
            .rst_n     (rst_n),
            .ev_i      (ev_pulse[g*EV_W +: EV_W]),
            .ctl_we_i  (ctl_we_w[g]),
            .stat_we_i (stat_we_w[g]),
            .wdata_i   (bus_wdata[EV_W-1:0]),
            .ctl_o     (ctl_w[g]),
            .stat_o    (stat_w[g]),
            .level_o   (level_w[g])
        );

        dirq_pend_fsm u_fsm (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (level_w[g]),
            .clr_i   (pend_clr_w[g]),
            .pend_o  (pend_w[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_we_w) begin
            en_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    assign irq = |(pend_w & en_q);

    AST_IRQ_FALL_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(bus_sel && bus_wr)); // R8

endmodule

// File: tb/dma_irq_merge_test.sv
module dma_irq_merge_test;

    localparam int NCH = 4;
    localparam int NEV = 5;
    localparam int AW  = 12;
    localparam int DW  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NCH*NEV-1:0] ev_pulse = '0;
    logic [NCH-1:0]    ch_idle = '0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic              irq;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dma_irq_merge #(.NUM_CH(NCH), .EV_W(NEV), .ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .ev_pulse(ev_pulse), .ch_idle(ch_idle),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [AW-1:0] ch_addr(int ch, logic [7:0] off);
        return AW'(12'h100 + ch * 12'h100 + off);
    endfunction

    task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse(int ch, logic [NEV-1:0] bits);
        @(negedge clk);
        ev_pulse = '0;
        ev_pulse[ch*NEV +: NEV] = bits;
        @(negedge clk);
        ev_pulse = '0;
    endtask

    task automatic t_reset();
        logic [DW-1:0] d;
        rd(12'h000, d); chk("R1 pending", d, 0);
        rd(12'h010, d); chk("R1 enable", d, 0);
        rd(ch_addr(0, 8'h40), d); chk("R1 ctl0", d, 0);
        rd(ch_addr(3, 8'h44), d); chk("R1 stat3", d, 0);
        chk("R1 irq", DW'(irq), 0);
    endtask

    task automatic t_events();
        logic [DW-1:0] d;
        for (int k = 0; k < NEV; k++) begin
            pulse(1, NEV'(1 << k));
            rd(ch_addr(1, 8'h44), d);
            chk("R2 sticky bit", d, DW'((1 << (k + 1)) - 1));
        end
        @(negedge clk);
        rd(12'h000, d); chk("R4 no pend with ctl zero", d, 0);
    endtask

    task automatic t_stat_clear();
        logic [DW-1:0] d;
        wr(ch_addr(1, 8'h44), 32'hFFFF_FF15);
        rd(ch_addr(1, 8'h44), d); chk("R3 keep ones", d, 32'h15);
        // status zeroed while bit 1 pulses on the same edge
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = ch_addr(1, 8'h44); bus_wdata = 0;
        ev_pulse[1*NEV +: NEV] = 5'b00010;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; ev_pulse = '0;
        rd(ch_addr(1, 8'h44), d); chk("R3 event wins over clear", d, 32'h02);
    endtask

    task automatic t_pend_set();
        logic [DW-1:0] d;
        wr(ch_addr(2, 8'h40), 32'h04);
        rd(ch_addr(2, 8'h40), d); chk("R4 ctl readback", d, 32'h04);
        pulse(2, 5'b00001);
        @(negedge clk);
        rd(12'h000, d); chk("R4 masked bit no pend", d, 0);
        pulse(2, 5'b00100);
        rd(12'h000, d); chk("R5 not yet after one edge", d, 0);
        @(negedge clk);
        rd(12'h000, d); chk("R5 pend after two edges", d, 32'h4);
        chk("R8 irq off when disabled", DW'(irq), 0);
        wr(12'h010, 32'h4);
        rd(12'h010, d); chk("R7 enable readback", d, 32'h4);
        chk("R8 irq on", DW'(irq), 1);
    endtask

    task automatic t_pend_clear();
        logic [DW-1:0] d;
        wr(ch_addr(2, 8'h44), 0);
        @(negedge clk);
        rd(12'h000, d); chk("R5 pend survives status clear", d, 32'h4);
        wr(12'h000, 32'h0);
        rd(12'h000, d); chk("R6 zero write no effect", d, 32'h4);
        wr(12'h000, 32'h4);
        rd(12'h000, d); chk("R6 w1c clears", d, 0);
        chk("R8 irq drops", DW'(irq), 0);
    endtask

    task automatic t_reassert();
        logic [DW-1:0] d;
        wr(ch_addr(3, 8'h40), 32'h01);
        pulse(3, 5'b00001);
        @(negedge clk);
        rd(12'h000, d); chk("R5 ch3 pend", d, 32'h8);
        wr(12'h000, 32'h8);
        rd(12'h000, d); chk("R6 low one cycle", d, 0);
        @(negedge clk);
        rd(12'h000, d); chk("R6 sets again", d, 32'h8);
    endtask

    task automatic t_collide();
        logic [DW-1:0] d;
        wr(ch_addr(3, 8'h44), 0);
        @(negedge clk);
        rd(12'h000, d); chk("R5 ch3 held", d, 32'h8);
        ev_pulse[3*NEV +: NEV] = 5'b00001;
        @(negedge clk);
        ev_pulse = '0;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h000; bus_wdata = 32'h8;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(12'h000, d); chk("R6 rise beats clear", d, 32'h8);
    endtask

    task automatic t_idle_unused();
        logic [DW-1:0] d;
        ch_idle = 4'b1010;
        rd(12'h02C, d); chk("R9 idle word", d, 32'hA);
        wr(12'h02C, 32'h5);
        rd(12'h02C, d); chk("R9 write ignored", d, 32'hA);
        wr(12'h020, 32'hFFFF_FFFF);
        rd(12'h020, d); chk("R10 hole reads zero", d, 0);
        wr(12'h500, 32'hFFFF_FFFF);
        wr(12'h540, 32'hFFFF_FFFF);
        rd(12'h540, d); chk("R10 beyond channels zero", d, 0);
        rd(12'h010, d); chk("R10 enable untouched", d, 32'h4);
        rd(ch_addr(0, 8'h40), d); chk("R10 ctl0 untouched", d, 0);
        rd(ch_addr(0, 8'h48), d); chk("R10 channel hole zero", d, 0);
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_events();
        t_stat_clear();
        t_pend_set();
        t_pend_clear();
        t_reassert();
        t_collide();
        t_idle_unused();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule